// File: doc/BRIEF.md
# Receive Frame Tag Shift Register

This block collects a short tag for every received frame. External address logic watches the receive nibble stream. After the start-of-data strobe, it shifts tag bits in one per receive clock, using a serial data input qualified by an enable input. Each accepted bit enters at bit 0, and the bits already held move up one place. The most significant bit therefore goes in first, and a short tag ends up right-aligned.

The shift window closes when the receive data-valid signal drops. On that edge the block copies the tag into bits 30:16 of a 32-bit receive status word and raises a one-cycle valid pulse. It then clears the tag for the next frame.

Two enable controls gate the reported tag: an address-interface select and a tag-feature enable. If either one is low when the frame ends, the reported field is zero.

Top module: `rxTagUnit`

## Requirements
- R1: After reset, statusWord is 0 and statusValid is 0.
- R2: Each accepted bit enters tag bit 0, and the earlier bits move up one place. A tag of N < 15 bits occupies tag bits N-1:0 with zeros above, and the first bit sent lands in bit N-1.
- R3: A bit is accepted only on a rising clock edge where tagEn is 1. Cycles with tagEn at 0 leave the tag unchanged.
- R4: While rxDv is 1, tag input is ignored until dataStart has been sampled high. This includes the cycle in which dataStart itself is sampled high. Acceptance begins on the next edge.
- R5: Once rxDv is sampled low, tag input is ignored until the next frame's dataStart.
- R6: When more than 15 bits are accepted, only the 15 most recent are kept.
- R7: On the first edge where rxDv is sampled 0 after being 1, statusWord[30:16] takes the tag and statusValid is 1 for exactly the following cycle.
- R8: statusWord bits 31 and 15:0 are always 0.
- R9: The reported field is 0 if addrIfSel or tagFeatureEn is 0 at the frame-end edge.
- R10: The tag is cleared between frames, so no bit from one frame appears in the next.
- R11: statusWord changes only in the cycle where statusValid is 1, and holds otherwise.
- R12: Repeated dataStart pulses inside a frame (byte boundaries) do not disturb the tag or the shift window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| rxDv | input | 1 | Receive data valid; a fall ends the frame |
| dataStart | input | 1 | Start-of-data strobe; also repeats at byte boundaries |
| tagData | input | 1 | Serial tag bit |
| tagEn | input | 1 | Qualifies tagData on the current edge |
| addrIfSel | input | 1 | External address interface selected |
| tagFeatureEn | input | 1 | Frame tagging enabled |
| statusWord | output | 32 | Receive status word; tag in bits 30:16 |
| statusValid | output | 1 | One-cycle pulse when statusWord is updated |

## Verification
A bit sampled on a rising edge moves the internal tag at once but is not visible until the frame ends. The status word and the valid pulse change one register after the edge that first samples rxDv low. The driver changes inputs on falling clock edges. It pushes the expected status word into a queue when it starts each frame. The monitor samples on falling edges and compares only when statusValid is high, which is the cycle after the frame-end edge. Between frames, every falling-edge sample checks that the word has held its last value.

// File: rtl/rxTagPkg.sv
package rxTagPkg;
  // Strobes from the control unit to the tag datapath
  typedef struct packed {
    logic shiftEn;     // accept tagData into the tag this edge
    logic clearTag;    // frame not active: hold the tag at zero
    logic latchStatus; // frame ended: copy the tag into the status word
  } tagStrobesT;
endpackage

// File: rtl/rxTagCtrl.sv
module rxTagCtrl
  import rxTagPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxDv,
  input  logic       dataStart,
  input  logic       tagEn,
  output tagStrobesT strobes
);
  logic dvPrev;
  logic armed;

  // The window opens on the edge after the first start strobe and closes with rxDv
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dvPrev <= 1'b0;
      armed  <= 1'b0;
    end else begin
      dvPrev <= rxDv;
      if (!rxDv)
        armed <= 1'b0;
      else if (dataStart)
        armed <= 1'b1;
    end
  end

  always_comb begin
    strobes.shiftEn     = rxDv && armed && tagEn;
    strobes.clearTag    = !rxDv;
    strobes.latchStatus = dvPrev && !rxDv;
  end
endmodule

// File: rtl/rxTagPath.sv
module rxTagPath
  import rxTagPkg::*;
#(
  parameter int TAG_W    = 15,
  parameter int STATUS_W = 32,
  parameter int TAG_LSB  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  tagStrobesT          strobes,
  input  logic                tagData,
  input  logic                addrIfSel,
  input  logic                tagFeatureEn,
  output logic [STATUS_W-1:0] statusWord,
  output logic                statusValid
);
  localparam int TAG_MSB = TAG_LSB + TAG_W - 1;

  logic [TAG_W-1:0]    shiftReg;
  logic [TAG_W-1:0]    gatedTag;
  logic [STATUS_W-1:0] placedWord;
  logic [STATUS_W-1:0] statusReg;
  logic                validReg;

  // Newest bit enters at the bottom; the top bit falls off on overflow
  always_ff @(posedge clk) begin
    if (!rstN)
      shiftReg <= '0;
    else if (strobes.clearTag)
      shiftReg <= '0;
    else if (strobes.shiftEn)
      shiftReg <= {shiftReg[TAG_W-2:0], tagData};
  end

  assign gatedTag = (addrIfSel && tagFeatureEn) ? shiftReg : '0;

  // Place the tag field inside the status word; every other bit is tied low
  for (genvar i = 0; i < STATUS_W; i++) begin : g_place
    if (i >= TAG_LSB && i <= TAG_MSB) begin : g_field
      assign placedWord[i] = gatedTag[i - TAG_LSB];
    end else begin : g_zero
      assign placedWord[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg <= '0;
      validReg  <= 1'b0;
    end else begin
      validReg <= strobes.latchStatus;
      if (strobes.latchStatus)
        statusReg <= placedWord;
    end
  end

  assign statusWord  = statusReg;
  assign statusValid = validReg;
endmodule

// File: rtl/rxTagUnit.sv
module rxTagUnit
  import rxTagPkg::*;
#(
  parameter int TAG_W    = 15,
  parameter int STATUS_W = 32,
  parameter int TAG_LSB  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxDv,
  input  logic                dataStart,
  input  logic                tagData,
  input  logic                tagEn,
  input  logic                addrIfSel,
  input  logic                tagFeatureEn,
  output logic [STATUS_W-1:0] statusWord,
  output logic                statusValid
);
  tagStrobesT strobes;

  rxTagCtrl ctrlI (
    .clk       (clk),
    .rstN      (rstN),
    .rxDv      (rxDv),
    .dataStart (dataStart),
    .tagEn     (tagEn),
    .strobes   (strobes)
  );

  rxTagPath #(
    .TAG_W    (TAG_W),
    .STATUS_W (STATUS_W),
    .TAG_LSB  (TAG_LSB)
  ) pathI (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .tagData      (tagData),
    .addrIfSel    (addrIfSel),
    .tagFeatureEn (tagFeatureEn),
    .statusWord   (statusWord),
    .statusValid  (statusValid)
  );
endmodule

// File: rtl/rxTagChk.sv
module rxTagChk #(
  parameter int TAG_W    = 15,
  parameter int STATUS_W = 32,
  parameter int TAG_LSB  = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                rxDv,
  input logic                addrIfSel,
  input logic                tagFeatureEn,
  input logic [STATUS_W-1:0] statusWord,
  input logic                statusValid
);
  localparam logic [STATUS_W-1:0] FIELD_MASK =
    STATUS_W'(((64'(1) << TAG_W) - 64'(1)) << TAG_LSB);

  AST_VALID_ON_END: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rxDv) && !rxDv) |=> statusValid); // R7

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |=> !statusValid); // R7

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord & ~FIELD_MASK) == '0); // R8

  AST_GATED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rxDv) && !rxDv && !(addrIfSel && tagFeatureEn))
      |=> (statusWord & FIELD_MASK) == '0); // R9

  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statusWord) |-> statusValid); // R11
endmodule

bind rxTagUnit rxTagChk #(
  .TAG_W    (TAG_W),
  .STATUS_W (STATUS_W),
  .TAG_LSB  (TAG_LSB)
) chkI (
  .clk          (clk),
  .rstN         (rstN),
  .rxDv         (rxDv),
  .addrIfSel    (addrIfSel),
  .tagFeatureEn (tagFeatureEn),
  .statusWord   (statusWord),
  .statusValid  (statusValid)
);

// File: tb/rxTagUnit_tb_top.sv
`timescale 1ns/1ps
module rxTagUnit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxDv = 1'b0;
  logic        dataStart = 1'b0;
  logic        tagData = 1'b0;
  logic        tagEn = 1'b0;
  logic        addrIfSel = 1'b1;
  logic        tagFeatureEn = 1'b1;
  logic [31:0] statusWord;
  logic        statusValid;

  int vecCount = 0;
  int missCount = 0;
  int pulseCount = 0;
  int frameCount = 0;
  bit monOn = 1'b0;
  bit finished = 1'b0;
  logic [31:0] expQ[$];
  logic [31:0] lastWord = '0;

  always #10 clk = ~clk; // 50 MHz

  rxTagUnit dut_i (
    .clk(clk), .rstN(rstN), .rxDv(rxDv), .dataStart(dataStart),
    .tagData(tagData), .tagEn(tagEn), .addrIfSel(addrIfSel),
    .tagFeatureEn(tagFeatureEn), .statusWord(statusWord),
    .statusValid(statusValid)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one frame and push its expected status word.
  // gapEvery: insert a cycle with tagEn low after every gapEvery bits (0 = none)
  // junk: cycles with tagEn high before the strobe and after rxDv falls
  task automatic sendFrame(input logic [63:0] bits, input int nBits,
                           input int gapEvery, input int junk,
                           input bit reStrobe, input bit sel, input bit fen);
    logic [14:0] model = '0;
    for (int i = nBits - 1; i >= 0; i--) model = {model[13:0], bits[i]};
    expQ.push_back((sel && fen) ? {1'b0, model, 16'h0} : 32'h0);
    frameCount++;
    @(negedge clk);
    addrIfSel = sel; tagFeatureEn = fen;
    rxDv = 1'b1;
    for (int j = 0; j < junk; j++) begin // R4: ignored before strobe
      tagEn = 1'b1; tagData = 1'b1; dataStart = 1'b0;
      @(negedge clk);
    end
    dataStart = 1'b1; tagEn = 1'b1; tagData = 1'b1; // R4: strobe cycle ignored
    @(negedge clk);
    dataStart = 1'b0;
    for (int i = nBits - 1; i >= 0; i--) begin
      tagEn = 1'b1; tagData = bits[i];
      dataStart = reStrobe && (i % 4 == 0); // R12
      @(negedge clk);
      if (gapEvery != 0 && (i % gapEvery == 0)) begin // R3
        tagEn = 1'b0; tagData = 1'b1; dataStart = 1'b0;
        @(negedge clk);
      end
    end
    rxDv = 1'b0; dataStart = 1'b0;
    tagEn = (junk != 0); tagData = 1'b1; // R5: ignored after the fall
    for (int j = 0; j < junk + 3; j++) @(negedge clk);
    tagEn = 1'b0; tagData = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: compare on the pulse, check the hold otherwise
  always @(negedge clk) begin
    if (monOn) begin
      if (statusValid) begin
        pulseCount++;
        if (expQ.size() == 0) begin
          check(1'b0, "R7 unexpected pulse", statusWord, lastWord);
        end else begin
          logic [31:0] e;
          e = expQ.pop_front();
          check(statusWord === e, "R2/R3/R4/R5/R6/R8/R9/R10/R12 status word",
                statusWord, e);
        end
        lastWord = statusWord;
      end else begin
        check(statusWord === lastWord, "R11 hold", statusWord, lastWord);
      end
    end
  end

  initial begin
    #3000000;
    if (!finished) begin
      vecCount++; missCount++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(statusWord === 32'h0, "R1 reset word", statusWord, 32'h0);
    check(statusValid === 1'b0, "R1 reset valid", {31'h0, statusValid}, 32'h0);
    monOn = 1'b1;
    sendFrame(64'h6B3D, 15, 0, 0, 0, 1, 1);         // R2 R7 full tag
    sendFrame(64'h16, 5, 0, 0, 0, 1, 1);            // R2 short tag, R10
    sendFrame(64'h2A5, 10, 3, 0, 0, 1, 1);          // R3 gaps
    sendFrame(64'hF0F0F, 20, 0, 0, 0, 1, 1);        // R6 overflow
    sendFrame(64'h7FFF, 15, 0, 0, 0, 0, 1);         // R9 select low
    sendFrame(64'h7FFF, 15, 0, 0, 0, 1, 0);         // R9 feature low
    sendFrame(64'h0D, 4, 0, 3, 1, 1, 1);            // R4 R5 R12
    sendFrame(64'h0, 0, 0, 2, 0, 1, 1);             // R10 empty tag
    sendFrame(64'h1234, 13, 2, 1, 1, 1, 1);         // mixed
    repeat (4) @(negedge clk);
    monOn = 1'b0;
    check(pulseCount == frameCount, "R7 pulse count", pulseCount, frameCount);
    check(expQ.size() == 0, "R7 pending results", expQ.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule